// File: doc/BRIEF.md
# Segmented DAC Cell-Enable Decoder

This block sits between a digital sample stream and the current-cell matrix of a 12-bit segmented current-steering converter. Each sample is split into two parts. The upper 8 bits are a thermometer level that sets how many equal unary cells conduct. The lower 4 bits drive four binary-weighted cells directly.

The unary cells sit in a 16 x 16 matrix. They do not turn on in row order. The matrix is viewed as 16 regions of 4 x 4 cells. Each new level lands in a different region from the level before it. Inside each run of 16 levels, every region is used once, and all 16 cells of that run sit at the same spot within their regions. The next run uses the point-mirrored spot. Gradient errors across the die therefore spread out instead of building up.

One matrix position is reserved as a bias cell and is never driven by data. Every enable is retimed in a single output register stage, so all control lines change on the same clock edge.

Top module: `segdac_frontend`

## Requirements
- R1: `binEn[i]` equals bit i of the sample for i = 0..3, and the upper 8 bits of the sample have no effect on `binEn`.
- R2: The number of asserted bits in `unaryEn` equals `sampleIn[11:4]` (0..255).
- R3: The enable set is monotonic in the code. For a higher code, the set of enabled cells is a superset of the set for any lower code.
- R4: Cell index 236 (row 14, column 12) is the reserved bias cell. It is never asserted, including at full-scale code 255.
- R5: Cell index p = row*16 + col. Its region is `{row[3:2], col[3:2]}` and its sub-position is `{row[1:0], col[1:0]}`. The cell added when the code steps from k to k+1 is in a different region from the cell added from k-1 to k. This also holds across the boundary between runs of 16.
- R6: For each run of levels 16g..16g+15, the 16 added cells cover all 16 regions, one each.
- R7: All cells added within one run share one sub-position. The sub-position of an odd run is the bitwise complement (point mirror) of the sub-position of the even run before it.
- R8: A sample applied before clock edge n appears on all outputs together after edge n+1. One edge after the change, the outputs still show the previous sample.
- R9: While reset is held, and until the first sample has passed both stages after reset release, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rstN | input | 1 | Synchronous reset, active low |
| sampleIn | input | 12 | Sample code; upper 8 bits unary level, lower 4 bits binary |
| unaryEn | output | 256 | Registered enable for each matrix cell, index row*16+col |
| binEn | output | 4 | Registered enables of the binary-weighted cells |

## Verification
The switching order is hard to see at the ports. Only the full enable vector is visible, and the order shows up only as which single cell appears between one code and the next.

The stimulus therefore walks the code upward one level at a time, holding each level for the full pipeline delay. At each step it takes the newly set cell from the difference of two output vectors. From that cell's position it derives the region and sub-position, and checks the hop, coverage and mirroring rules over every run of 16 levels, including the wrap into the run that ends on the reserved cell.

// File: rtl/segdac_pkg.sv
package segdac_pkg;

  // Strobes issued by the sequencer to the datapath.
  typedef struct packed {
    logic loadDecode;  // capture the split sample into the decode stage
    logic loadLatch;   // retime all cell enables into the output register
  } strobe_t;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_FILL = 2'd1,
    SEQ_RUN  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/segdac_ctrl.sv
module segdac_ctrl
  import segdac_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  output strobe_t strobe
);

  seq_state_e seqState, seqNext;

  always_comb begin
    seqNext = seqState;
    unique case (seqState)
      SEQ_IDLE: seqNext = SEQ_FILL;
      SEQ_FILL: seqNext = SEQ_RUN;
      SEQ_RUN:  seqNext = SEQ_RUN;
      default:  seqNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) seqState <= SEQ_IDLE;
    else       seqState <= seqNext;
  end

  always_comb begin
    strobe.loadDecode = (seqState != SEQ_IDLE);
    strobe.loadLatch  = (seqState == SEQ_RUN);
  end

  // R8: the output register only loads once the decode stage holds data
  p_latch_after_decode_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadLatch |-> $past(strobe.loadDecode));

  // R9: pipeline fill takes exactly one cycle before the latch runs
  p_fill_then_run_r9: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == SEQ_FILL) |=> strobe.loadLatch);

endmodule

// File: rtl/segdac_datapath.sv
module segdac_datapath
  import segdac_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned BIN_W    = 4
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  strobe_t                                 strobe,
  input  logic [SAMPLE_W-1:0]                     sampleIn,
  output logic [(1 << (SAMPLE_W - BIN_W)) - 1:0]  unaryEn,
  output logic [BIN_W-1:0]                        binEn
);

  localparam int unsigned THERM_W   = SAMPLE_W - BIN_W;  // unary level width
  localparam int unsigned HALF      = THERM_W / 2;       // row / column width
  localparam int unsigned QTR       = HALF / 2;          // region coordinate width
  localparam int unsigned CELLS     = 1 << THERM_W;
  localparam int unsigned RSV_LEVEL = CELLS - 1;         // level no code reaches

  // ---------------- ordering functions ----------------
  function automatic logic [HALF-1:0] revBits(input logic [HALF-1:0] v);
    logic [HALF-1:0] r;
    for (int i = 0; i < HALF; i++) r[i] = v[HALF-1-i];
    return r;
  endfunction

  // Sub-position -> run index. Even runs use a sub-position with MSB 0,
  // odd runs use its complement (centro-symmetric partner).
  function automatic logic [HALF-1:0] runOfSub(input logic [HALF-1:0] s);
    logic [HALF-1:0] base;
    base = s[HALF-1] ? ~s : s;
    return {base[HALF-2:0], s[HALF-1]};
  endfunction

  // Region visited at step r of run g is revBits(r+1) ^ g. Inverted here.
  function automatic logic [HALF-1:0] stepOfRegion(input logic [HALF-1:0] region,
                                                   input logic [HALF-1:0] run);
    return HALF'(revBits(region ^ run) - 1'b1);
  endfunction

  function automatic logic [THERM_W-1:0] levelOfCell(input logic [THERM_W-1:0] p);
    logic [HALF-1:0] row, col, region, sub, run, step;
    row    = p[THERM_W-1:HALF];
    col    = p[HALF-1:0];
    region = {row[HALF-1:QTR], col[HALF-1:QTR]};
    sub    = {row[QTR-1:0],    col[QTR-1:0]};
    run    = runOfSub(sub);
    step   = stepOfRegion(region, run);
    return {run, step};
  endfunction

  // ---------------- stage 1: split ----------------
  logic [THERM_W-1:0] thermQ;
  logic [BIN_W-1:0]   binQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      thermQ <= '0;
      binQ   <= '0;
    end else if (strobe.loadDecode) begin
      thermQ <= sampleIn[SAMPLE_W-1:BIN_W];
      binQ   <= sampleIn[BIN_W-1:0];
    end
  end

  // ---------------- cell decode ----------------
  logic [CELLS-1:0] cellNext;

  for (genvar p = 0; p < CELLS; p++) begin : g_cell
    localparam logic [THERM_W-1:0] LVL = levelOfCell(THERM_W'(p));
    if (LVL == THERM_W'(RSV_LEVEL)) begin : g_reserved
      assign cellNext[p] = 1'b0;
      // R4: the bias cell is never driven by data
      p_reserved_off_r4: assert property (@(posedge clk) disable iff (!rstN)
        !unaryEn[p]);
    end else begin : g_data
      assign cellNext[p] = (LVL < thermQ);
    end
  end

  // ---------------- stage 2: output latch ----------------
  logic [CELLS-1:0] unaryQ;
  logic [BIN_W-1:0] binOutQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      unaryQ  <= '0;
      binOutQ <= '0;
    end else if (strobe.loadLatch) begin
      unaryQ  <= cellNext;
      binOutQ <= binQ;
    end
  end

  assign unaryEn = unaryQ;
  assign binEn   = binOutQ;

  // R2: number of conducting unary cells tracks the latched level
  p_cell_count_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.loadLatch) |-> ($countones(unaryEn) == int'($past(thermQ))));

  // R1: binary enables follow the low sample bits through the pipeline
  p_binary_pass_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.loadLatch) |-> (binEn == $past(binQ)));

  // R9: outputs stay cleared until the latch first loads
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadLatch |=> ((unaryEn == '0) && (binEn == '0)));

endmodule

// File: rtl/segdac_frontend.sv
module segdac_frontend
  import segdac_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned BIN_W    = 4
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  logic [SAMPLE_W-1:0]                     sampleIn,
  output logic [(1 << (SAMPLE_W - BIN_W)) - 1:0]  unaryEn,
  output logic [BIN_W-1:0]                        binEn
);

  strobe_t strobe;

  segdac_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe)
  );

  segdac_datapath #(
    .SAMPLE_W (SAMPLE_W),
    .BIN_W    (BIN_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .sampleIn (sampleIn),
    .unaryEn  (unaryEn),
    .binEn    (binEn)
  );

endmodule

// File: tb/segdac_frontend_tb_top.sv
module segdac_frontend_tb_top;

  localparam int RSV_CELL = 236;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [11:0]  sampleIn = '0;
  logic [255:0] unaryEn;
  logic [3:0]   binEn;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  segdac_frontend dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .sampleIn (sampleIn),
    .unaryEn  (unaryEn),
    .binEn    (binEn)
  );

  // {sample, expected unary count, expected binary enables}
  localparam logic [23:0] VEC [8] = '{
    {12'h000, 8'd0,   4'h0},
    {12'h001, 8'd0,   4'h1},
    {12'h010, 8'd1,   4'h0},
    {12'h7A5, 8'd122, 4'h5},
    {12'h80F, 8'd128, 4'hF},
    {12'hF0A, 8'd240, 4'hA},
    {12'hFFF, 8'd255, 4'hF},
    {12'h3C6, 8'd60,  4'h6}
  };

  task automatic check(input bit ok, input string req, input string detail);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", req, detail);
    end
  endtask

  task automatic apply(input logic [11:0] code);
    @(negedge clk) sampleIn = code;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: act=timeout exp=completion");
    finishRun();
  end

  initial begin
    logic [255:0] prev, cur, added;
    logic [3:0]   prevRegion, region, sub, runSub, evenSub;
    logic [15:0]  regionMask;
    int           idx;

    // ---- R9: reset state ----
    sampleIn = 12'hFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(unaryEn == '0, "R9", $sformatf("unary in reset act=%0d exp=0", $countones(unaryEn)));
    check(binEn == '0, "R9", $sformatf("bin in reset act=%h exp=0", binEn));
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(unaryEn == '0 && binEn == '0, "R9",
          $sformatf("after release act=%0d/%h exp=0/0", $countones(unaryEn), binEn));
    repeat (3) @(posedge clk);

    // ---- vector table: R1, R2 ----
    foreach (VEC[i]) begin
      apply(VEC[i][23:12]);
      check($countones(unaryEn) == int'(VEC[i][11:4]), "R2",
            $sformatf("count code=%h act=%0d exp=%0d", VEC[i][23:12],
                      $countones(unaryEn), VEC[i][11:4]));
      check(binEn == VEC[i][3:0], "R1",
            $sformatf("bin code=%h act=%h exp=%h", VEC[i][23:12], binEn, VEC[i][3:0]));
      check(!unaryEn[RSV_CELL], "R4", $sformatf("reserved code=%h act=1 exp=0", VEC[i][23:12]));
    end

    // ---- R1: upper bits do not disturb binary enables ----
    apply(12'h009);
    prev = unaryEn;
    apply(12'hFF9);
    check(binEn == 4'h9, "R1", $sformatf("bin with upper change act=%h exp=9", binEn));

    // ---- R8: latency and simultaneous update ----
    apply(12'h000);
    @(negedge clk) sampleIn = 12'h40C;
    @(posedge clk);
    @(negedge clk);
    check(unaryEn == '0 && binEn == 4'h0, "R8",
          $sformatf("one edge act=%0d/%h exp=0/0", $countones(unaryEn), binEn));
    @(posedge clk);
    @(negedge clk);
    check($countones(unaryEn) == 64 && binEn == 4'hC, "R8",
          $sformatf("two edges act=%0d/%h exp=64/c", $countones(unaryEn), binEn));

    // ---- ascending sweep: R2 R3 R4 R5 R6 R7 ----
    apply(12'h000);
    prev = unaryEn;
    prevRegion = '0;
    regionMask = '0;
    runSub = '0;
    evenSub = '0;
    for (int c = 0; c < 255; c++) begin
      apply(12'((c + 1) << 4));
      cur   = unaryEn;
      added = cur & ~prev;
      check((prev & ~cur) == '0, "R3", $sformatf("lost cells at level %0d act=%0d exp=0",
                                                c + 1, $countones(prev & ~cur)));
      check($countones(added) == 1, "R2", $sformatf("added at level %0d act=%0d exp=1",
                                                   c + 1, $countones(added)));
      check(!cur[RSV_CELL], "R4", $sformatf("reserved at level %0d act=1 exp=0", c + 1));
      idx = 0;
      for (int b = 0; b < 256; b++) if (added[b]) idx = b;
      region = {idx[7:6], idx[3:2]};
      sub    = {idx[5:4], idx[1:0]};
      if (c > 0)
        check(region != prevRegion, "R5",
              $sformatf("hop at level %0d act=%0d exp!=%0d", c, region, prevRegion));
      if (c % 16 == 0) begin
        regionMask = '0;
        runSub = sub;
        if ((c / 16) % 2 == 0) evenSub = sub;
        else check(sub == ~evenSub, "R7",
                   $sformatf("mirror run %0d act=%h exp=%h", c / 16, sub, ~evenSub));
      end else begin
        check(sub == runSub, "R7",
              $sformatf("sub-position level %0d act=%h exp=%h", c, sub, runSub));
      end
      regionMask[region] = 1'b1;
      if (c % 16 == 14 && c / 16 == 15)
        check(regionMask == 16'h7FFF | (16'h1 << region) || $countones(regionMask) == 15, "R6",
              $sformatf("last run mask act=%h exp=15 regions", regionMask));
      if (c % 16 == 15)
        check(regionMask == 16'hFFFF, "R6",
              $sformatf("run %0d regions act=%h exp=ffff", c / 16, regionMask));
      prevRegion = region;
      prev = cur;
    end

    // ---- full scale: R4 and R2 ----
    check($countones(unaryEn) == 255 && !unaryEn[RSV_CELL], "R4",
          $sformatf("full scale act=%0d/%b exp=255/0", $countones(unaryEn), unaryEn[RSV_CELL]));

    // ---- descending spot checks: R3 ----
    apply(12'hA00);
    prev = unaryEn;
    apply(12'h500);
    check((unaryEn & ~prev) == '0, "R3",
          $sformatf("lower code subset act=%0d extra exp=0", $countones(unaryEn & ~prev)));
    check($countones(unaryEn) == 80, "R2", $sformatf("count act=%0d exp=80", $countones(unaryEn)));

    // ---- reset mid-run clears outputs: R9 ----
    @(negedge clk) rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(unaryEn == '0 && binEn == '0, "R9",
          $sformatf("re-reset act=%0d/%h exp=0/0", $countones(unaryEn), binEn));
    rstN = 1'b1;

    finishRun();
  end

endmodule